// File: doc/BRIEF.md
# DRAM Bank with Open-Row Buffer and Prefetch Bursts

This block is a synthesizable behavioural model of a single DRAM bank. It keeps one row open in a sense-amplifier latch and serves read requests that carry a row and a column address. A host presents each request on a valid/ready port. The bank answers with a burst of adjacent words on a valid/last stream.

When the requested row is already open, the bank goes straight to the column access. For any other case, it first runs a precharge and then a row activation, and each of these phases has its own programmable cycle count. Activation is the slow phase, so by default its latency is several times the column latency.

A single column command loads a whole aligned group of words into a prefetch buffer. The bank then sends these words out one per beat, and no further column addresses are needed. For each request, a flag reports whether it hit the open row or missed it. Row contents come from a fixed function of the row and column, so every returned word can be predicted.

Top module: `dram_bank_prefetch`

## Requirements
- R1: After reset, `req_ready_o` is 1 and `data_valid_o` is 0. No row is open, so the first accepted request is a row miss.
- R2: A request accepted while its row is not open is followed by exactly `T_PRE + T_ACT + T_COL` cycles with `data_valid_o` low, and then by the burst.
- R3: A request accepted while its row is open is followed by exactly `T_COL` cycles with `data_valid_o` low, and then by the burst.
- R4: A burst is `PF_DEPTH` (8) consecutive beats of `data_valid_o`. `data_last_o` is high on the eighth beat only. Outside a burst, `data_valid_o` is low.
- R5: Beat i of a burst for row r and column c carries word(r, (c with its low 3 bits cleared) + i), where word(r, k) = ((r*29) XOR (k*7)) + 0x3C mod 256. The burst stays inside that aligned group of 8 and never wraps.
- R6: `req_ready_o` is low from the cycle after acceptance until the cycle after the last beat. A valid request presented while `req_ready_o` is low has no effect on the outputs.
- R7: During a burst, `hit_o` is 1 if the request hit the open row and 0 if it missed. It is constant across the burst.
- R8: A request to a different row closes the open row and opens the new one. A later request to the old row is therefore a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Read request valid |
| req_ready_o | output | 1 | Bank idle, request accepted when valid |
| req_row_i | input | ROW_W | Row address |
| req_col_i | input | COL_W | Column address (word index in the row) |
| data_valid_o | output | 1 | Burst beat valid |
| data_o | output | 8 | Burst word |
| data_last_o | output | 1 | Final beat of the burst |
| hit_o | output | 1 | Current request hit the open row |

## Verification
Two of the bank's functions can fall in the same cycle: the final beat of a burst and the arrival of the next request. The bench holds `req_valid_i` high, with a different row, through whole bursts and through the last beat. The model then expects that stray request to leave the outputs untouched, and expects acceptance only in the first idle cycle. Every clock, a behavioural model predicts ready, valid, last, the hit flag and the data. That model is a queue of expected beats, built from the latency formulas and the open-row state it tracks itself.

// File: rtl/dbp_pkg.sv
package dbp_pkg;
  localparam int unsigned WORD_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_ACT,
    ST_COL,
    ST_BURST
  } bank_state_e;

  // deterministic row content
  function automatic logic [WORD_W-1:0] row_word(input logic [15:0] row, input logic [15:0] col);
    logic [15:0] mix;
    mix = (row * 16'd29) ^ (col * 16'd7);
    return mix[WORD_W-1:0] + 8'h3C;
  endfunction
endpackage

// File: rtl/dbp_row_latch.sv
module dbp_row_latch
  import dbp_pkg::*;
#(
  parameter int unsigned ROW_W = 8,
  parameter int unsigned COL_W = 8,
  localparam int unsigned ROW_WORDS = 1 << COL_W
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  close_i,
  input  logic                                  load_i,
  input  logic [ROW_W-1:0]                      row_i,
  output logic                                  open_o,
  output logic [ROW_W-1:0]                      open_row_o,
  output logic [ROW_WORDS-1:0][WORD_W-1:0]      words_o
);
  logic             open_q;
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      row_q  <= '0;
    end else if (load_i) begin
      open_q <= 1'b1;
      row_q  <= row_i;
    end else if (close_i) begin
      open_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < ROW_WORDS; g++) begin : g_sense
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) words_o[g] <= '0;
      else if (load_i) words_o[g] <= row_word(16'(row_i), 16'(g));
    end
  end

  assign open_o     = open_q;
  assign open_row_o = row_q;
endmodule

// File: rtl/dbp_ctrl.sv
module dbp_ctrl
  import dbp_pkg::*;
#(
  parameter int unsigned ROW_W = 8,
  parameter int unsigned COL_W = 8,
  parameter int unsigned T_PRE = 3,
  parameter int unsigned T_ACT = 12,
  parameter int unsigned T_COL = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [ROW_W-1:0] req_row_i,
  input  logic [COL_W-1:0] req_col_i,
  input  logic             row_open_i,
  input  logic [ROW_W-1:0] open_row_i,
  input  logic             burst_last_i,
  output logic             req_ready_o,
  output logic             close_o,
  output logic             act_done_o,
  output logic             col_done_o,
  output logic             hit_o,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o
);
  localparam int unsigned T_MAX = (T_ACT > T_PRE) ? ((T_ACT > T_COL) ? T_ACT : T_COL)
                                                  : ((T_PRE > T_COL) ? T_PRE : T_COL);
  localparam int unsigned CNT_W = $clog2(T_MAX + 1);

  bank_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             hit_q;
  logic             accept, is_hit, cnt_zero;

  assign accept   = req_valid_i && (state_q == ST_IDLE);
  assign is_hit   = row_open_i && (open_row_i == req_row_i);
  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      row_q   <= '0;
      col_q   <= '0;
      hit_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          row_q <= req_row_i;
          col_q <= req_col_i;
          hit_q <= is_hit;
          if (is_hit) begin
            state_q <= ST_COL;
            cnt_q   <= CNT_W'(T_COL - 1);
          end else begin
            state_q <= ST_PRE;
            cnt_q   <= CNT_W'(T_PRE - 1);
          end
        end
        ST_PRE: if (cnt_zero) begin
          state_q <= ST_ACT;
          cnt_q   <= CNT_W'(T_ACT - 1);
        end else cnt_q <= cnt_q - 1'b1;
        ST_ACT: if (cnt_zero) begin
          state_q <= ST_COL;
          cnt_q   <= CNT_W'(T_COL - 1);
        end else cnt_q <= cnt_q - 1'b1;
        ST_COL: if (cnt_zero) state_q <= ST_BURST;
                else cnt_q <= cnt_q - 1'b1;
        ST_BURST: if (burst_last_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign close_o     = (state_q == ST_PRE);
  assign act_done_o  = (state_q == ST_ACT) && cnt_zero;
  assign col_done_o  = (state_q == ST_COL) && cnt_zero;
  assign hit_o       = hit_q;
  assign row_o       = row_q;
  assign col_o       = col_q;

  // R8: activation only lands after the precharge has closed the old row
  a_r8_closed_before_act: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_done_o |-> !row_open_i);
  // R6: no acceptance while a burst is still being streamed
  a_r6_no_accept_in_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_last_i |-> !req_ready_o);
endmodule

// File: rtl/dbp_burst.sv
module dbp_burst
  import dbp_pkg::*;
#(
  parameter int unsigned COL_W    = 8,
  parameter int unsigned PF_DEPTH = 8,
  localparam int unsigned ROW_WORDS = 1 << COL_W,
  localparam int unsigned PF_W      = $clog2(PF_DEPTH),
  localparam int unsigned GRP_W     = COL_W - PF_W
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             load_i,
  input  logic [GRP_W-1:0]                 group_i,
  input  logic [ROW_WORDS-1:0][WORD_W-1:0] words_i,
  output logic                             valid_o,
  output logic [WORD_W-1:0]                data_o,
  output logic                             last_o
);
  logic [PF_DEPTH-1:0][WORD_W-1:0] buf_q;
  logic [PF_W-1:0]                 beat_q;
  logic                            valid_q;

  for (genvar i = 0; i < PF_DEPTH; i++) begin : g_pf
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) buf_q[i] <= '0;
      else if (load_i) buf_q[i] <= words_i[{group_i, PF_W'(i)}];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      beat_q  <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      beat_q  <= '0;
    end else if (valid_q) begin
      if (beat_q == PF_W'(PF_DEPTH - 1)) valid_q <= 1'b0;
      else beat_q <= beat_q + 1'b1;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = buf_q[beat_q];
  assign last_o  = valid_q && (beat_q == PF_W'(PF_DEPTH - 1));

  // R4: a burst only ends through its last beat
  a_r4_end_on_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(valid_o) |-> $past(last_o));
  a_r4_last_in_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);
endmodule

// File: rtl/dram_bank_prefetch.sv
module dram_bank_prefetch
  import dbp_pkg::*;
#(
  parameter int unsigned ROW_W    = 8,
  parameter int unsigned COL_W    = 8,
  parameter int unsigned PF_DEPTH = 8,
  parameter int unsigned T_PRE    = 3,
  parameter int unsigned T_ACT    = 12,
  parameter int unsigned T_COL    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  output logic              data_valid_o,
  output logic [WORD_W-1:0] data_o,
  output logic              data_last_o,
  output logic              hit_o
);
  localparam int unsigned ROW_WORDS = 1 << COL_W;
  localparam int unsigned PF_W      = $clog2(PF_DEPTH);

  logic                             row_open, close, act_done, col_done;
  logic [ROW_W-1:0]                 open_row, cur_row;
  logic [COL_W-1:0]                 cur_col;
  logic [ROW_WORDS-1:0][WORD_W-1:0] row_words;

  dbp_ctrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .T_PRE(T_PRE), .T_ACT(T_ACT), .T_COL(T_COL)
  ) u_ctrl (
    .clk_i, .rst_ni, .req_valid_i, .req_row_i, .req_col_i,
    .row_open_i(row_open), .open_row_i(open_row), .burst_last_i(data_last_o),
    .req_ready_o, .close_o(close), .act_done_o(act_done), .col_done_o(col_done),
    .hit_o, .row_o(cur_row), .col_o(cur_col)
  );

  dbp_row_latch #(.ROW_W(ROW_W), .COL_W(COL_W)) u_latch (
    .clk_i, .rst_ni, .close_i(close), .load_i(act_done), .row_i(cur_row),
    .open_o(row_open), .open_row_o(open_row), .words_o(row_words)
  );

  dbp_burst #(.COL_W(COL_W), .PF_DEPTH(PF_DEPTH)) u_burst (
    .clk_i, .rst_ni, .load_i(col_done), .group_i(cur_col[COL_W-1:PF_W]),
    .words_i(row_words), .valid_o(data_valid_o), .data_o, .last_o(data_last_o)
  );

  // R2/R3: a burst always reads from an open row
  a_r2_burst_row_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |-> row_open);
  // R7: hit flag is constant across a burst
  a_r7_hit_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_valid_o && $past(data_valid_o)) |-> $stable(hit_o));
  // R6: port is closed while data streams
  a_r6_busy_in_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |-> !req_ready_o);
endmodule

// File: tb/dram_bank_prefetch_tb_top.sv
module dram_bank_prefetch_tb_top;
  localparam int T_PRE = 3, T_ACT = 12, T_COL = 2, PF = 8;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [7:0] req_row = '0, req_col = '0;
  logic       req_ready, dvalid, dlast, hit;
  logic [7:0] dout;

  always #4 clk = ~clk;

  dram_bank_prefetch dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_row_i(req_row), .req_col_i(req_col), .data_valid_o(dvalid), .data_o(dout),
    .data_last_o(dlast), .hit_o(hit)
  );

  typedef struct {
    bit       vld;
    int       data;
    bit       last;
    bit       hit;
    string    tag;
  } exp_t;

  exp_t q[$];
  int   vectors = 0, fails = 0;
  bit   open_v = 0;
  int   open_row_v = 0;
  bit   done = 0;

  function automatic int word_of(int r, int c);
    return (((r * 29) ^ (c * 7)) + 60) & 255;
  endfunction

  task automatic fail(string tag, string what, int act, int exp);
    fails++;
    $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
  endtask

  // one clock: check outputs, advance model, drive next inputs
  task automatic step(bit v, int r, int c, output bit accepted);
    exp_t e;
    bit   idle;
    @(negedge clk);
    idle = (q.size() == 0);
    if (idle) e = '{vld:0, data:0, last:0, hit:0, tag:"R4"};
    else e = q.pop_front();
    vectors++;
    if (req_ready !== idle) fail("R6", "req_ready", int'(req_ready), int'(idle));
    if (dvalid !== e.vld) fail(e.tag, "data_valid", int'(dvalid), int'(e.vld));
    if (dlast !== e.last) fail("R4", "data_last", int'(dlast), int'(e.last));
    if (e.vld) begin
      if (int'(dout) != e.data) fail("R5", "data", int'(dout), e.data);
      if (hit !== e.hit) fail("R7", "hit", int'(hit), int'(e.hit));
    end
    req_valid = v;
    req_row   = 8'(r);
    req_col   = 8'(c);
    accepted  = idle && v;
    if (accepted) begin
      bit h;
      int lat, base;
      h    = open_v && (open_row_v == r);
      lat  = h ? T_COL : T_PRE + T_ACT + T_COL;
      base = c & ~(PF - 1);
      for (int i = 0; i < lat; i++) q.push_back('{0, 0, 0, 0, h ? "R3" : "R2"});
      for (int i = 0; i < PF; i++)
        q.push_back('{1, word_of(r, base + i), i == PF - 1, h, "R4"});
      open_v = 1;
      open_row_v = r;
    end
  endtask

  task automatic request(int r, int c);
    bit acc = 0;
    while (!acc) step(1, r, c, acc);
  endtask

  // finish the current access, optionally holding a stray request on the port
  task automatic drain(bit stray);
    bit acc;
    while (q.size() != 0) step(stray, (open_row_v + 77) & 255, 8'hA5, acc);
    step(0, 0, 0, acc);
  endtask

  initial begin
    bit acc;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    step(0, 0, 0, acc);                    // R1 reset state
    request(5, 3);  drain(0);              // R1 first is miss, R2, R5
    request(5, 17); drain(0);              // R3 hit
    request(5, 255); drain(1);             // R5 last group no wrap, R6 stray held
    request(9, 0);  drain(1);              // R8 row switch
    request(5, 8);  drain(0);              // R8 old row now miss
    request(5, 100);                       // R6 back-to-back with stray during busy
    drain(1);
    request(5, 101); drain(0);
    for (int k = 0; k < 6; k++) begin
      request((k * 53) & 255, (k * 41) & 255);
      drain(k[0]);
      request((k * 53) & 255, (k * 97 + 9) & 255);
      drain(0);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule